// File: doc/BRIEF.md
# DMA Channel Register Interface

This block is the register front end of a multi-channel memory-to-memory DMA controller. A bus master reaches it through single-cycle accesses that are either 4 or 8 bytes wide. Each address is split into a channel number (the bits above the low twelve) and a register offset (the low twelve bits). For each channel the block holds a control register, a pending descriptor (config, byte count, destination, source) and a read-only active descriptor. When a transfer starts, the pending descriptor is copied into the active one.

Software writes the control register with the run bit set to start a channel. The block first checks the pending descriptor. If the descriptor is good, the block copies it, pulses a start strobe with the channel number and the active descriptor to the transfer engine, and marks the channel busy until the engine reports done or error. If the descriptor is bad, the block only raises the error status. Each channel drives two level interrupt lines: done and error, each gated by its own enable bit. Moving the data is the engine's job. The repeat, ordering and claim bits are stored and passed along, but have no effect inside this block.

Top module: `dmareg_top`

## Requirements
- R1: After reset every register of every channel reads zero, all interrupt lines are low and `start_valid` is low.
- R2: The pending byte count (0x008), destination (0x010) and source (0x018) are 64-bit registers. They can be written and read as one 8-byte access or as two 4-byte halves, with the upper half at offset +4. The pending config at 0x004 is a 32-bit register.
- R3: A control write (offset 0x000) with run (bit 1) set, to an idle channel holding a valid descriptor, does four things. It pulses `start_valid` one cycle later with `start_chan` and the descriptor. It copies the pending registers into the active registers at 0x104 (config), 0x108 (bytes), 0x110 (destination) and 0x118 (source). It clears the done (bit 30) and error (bit 31) status bits. It leaves run set.
- R4: A descriptor is invalid when any of these holds: the byte count is zero; write size (config bits 27:24) differs from read size (bits 31:28); or the byte count is not a multiple of 2^min(size,6). Starting an invalid descriptor produces no start strobe and sets the error status on top of the written control value.
- R5: An engine done pulse on a busy channel sets the done status (bit 30) and clears run. An engine error pulse sets the error status (bit 31) and clears run. Either pulse returns the channel to idle.
- R6: Interrupt line 2*ch is high exactly while done status and the done enable (bit 14) are both set. Line 2*ch+1 is high exactly while error status and the error enable (bit 15) are both set.
- R7: While a channel is busy, a control write changes only bits 14 and 15, and run does not start a new transfer.
- R8: Writes to the active registers are dropped.
- R9: An access whose channel number is not below the channel count reads zero, writes nothing, and raises `bad_access` for one cycle.
- R10: An access to an unmapped offset, a misaligned address, or an 8-byte access to a 32-bit register or to an upper half reads zero, writes nothing, and raises `bad_access` for one cycle.
- R11: Writes to one channel leave the registers of every other channel unchanged.
- R12: Read data and `bus_rvalid` appear one cycle after the read request. A 4-byte read returns its word in bits 31:0 with bits 63:32 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | ADDR_W | Byte address: channel above bit 11, offset in 11:0 |
| bus_wdata | input | 64 | Write data, 4-byte accesses use bits 31:0 |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data |
| bad_access | output | 1 | One-cycle flag for a rejected access |
| eng_done | input | NUM_CH | Per-channel transfer finished pulse |
| eng_err | input | NUM_CH | Per-channel transfer failed pulse |
| start_valid | output | 1 | Launch strobe |
| start_chan | output | CH_W | Channel being launched |
| start_cfg | output | 32 | Active config of the launched channel |
| start_bytes | output | 64 | Active byte count |
| start_dst | output | 64 | Active destination address |
| start_src | output | 64 | Active source address |
| irq | output | 2*NUM_CH | Done/error interrupt lines per channel |

## Verification
The assertions assume the bus raises `bus_valid` for one cycle per access and holds it low otherwise. They also assume the engine pulses done or error only for a channel it has started. The bench issues every access through a task that asserts the request for exactly one cycle, and it pulses the engine inputs only after a start strobe has been seen. Because the assertions assume these conditions rather than check them, an engine pulse to an idle channel would not be caught by them. The design ignores such a pulse, and the bench never produces one.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  typedef enum logic [3:0] {
    REG_NONE, REG_CTRL, REG_NCFG, REG_NBYTES, REG_NDST, REG_NSRC,
    REG_ECFG, REG_EBYTES, REG_EDST, REG_ESRC
  } reg_id_e;

  typedef enum logic [1:0] {PART_FULL, PART_LO, PART_HI} part_e;

  localparam int CTRL_CLAIM = 0;
  localparam int CTRL_RUN   = 1;
  localparam int CTRL_DIE   = 14;
  localparam int CTRL_EIE   = 15;
  localparam int CTRL_DONE  = 30;
  localparam int CTRL_ERR   = 31;
  localparam logic [31:0] CTRL_MASK = 32'hC000_C003;

  localparam int CFG_WSZ_LSB = 24;
  localparam int CFG_RSZ_LSB = 28;
  localparam int SZ_W        = 4;

  typedef struct packed {
    logic [31:0] cfg;
    logic [63:0] bytes;
    logic [63:0] dst;
    logic [63:0] src;
  } desc_t;

  function automatic logic [63:0] merge_part(input logic [63:0] old_v,
                                             input part_e part,
                                             input logic [63:0] wd);
    case (part)
      PART_LO: merge_part = {old_v[63:32], wd[31:0]};
      PART_HI: merge_part = {wd[31:0], old_v[31:0]};
      default: merge_part = wd;
    endcase
  endfunction

  function automatic logic [63:0] pick_part(input logic [63:0] v,
                                            input part_e part);
    case (part)
      PART_LO: pick_part = {32'h0, v[31:0]};
      PART_HI: pick_part = {32'h0, v[63:32]};
      default: pick_part = v;
    endcase
  endfunction

endpackage

// File: rtl/dmareg_desc_chk.sv
module dmareg_desc_chk
  import dmareg_pkg::*;
#(
  parameter int MAX_LOG2 = 6
) (
  input  logic [31:0] cfg,
  input  logic [63:0] bytes,
  output logic        ok
);
  logic [SZ_W-1:0] wsz, rsz, lg;
  logic [63:0]     mask;

  always_comb begin
    wsz  = cfg[CFG_WSZ_LSB +: SZ_W];
    rsz  = cfg[CFG_RSZ_LSB +: SZ_W];
    lg   = (wsz > SZ_W'(MAX_LOG2)) ? SZ_W'(MAX_LOG2) : wsz;
    mask = (64'd1 << lg) - 64'd1;
    ok   = (bytes != 64'd0) && (wsz == rsz) && ((bytes & mask) == 64'd0);
  end
endmodule

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              valid,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              bad,
  output logic [CH_W-1:0]   chan,
  output reg_id_e           reg_id,
  output part_e             part
);
  localparam int CHF_W = ADDR_W - 12;

  logic [CHF_W-1:0] chan_field;
  logic [11:0]      offset;
  logic             chan_ok;
  logic             map_ok;

  always_comb begin
    chan_field = addr[ADDR_W-1:12];
    offset     = addr[11:0];
    chan       = chan_field[CH_W-1:0];
    chan_ok    = {1'b0, chan_field} < (CHF_W+1)'(NUM_CH);
    reg_id     = REG_NONE;
    part       = wide ? PART_FULL : PART_LO;
    map_ok     = 1'b0;
    if (offset[1:0] == 2'b00) begin
      case (offset[11:2])
        10'h000: begin reg_id = REG_CTRL;   map_ok = !wide; end
        10'h001: begin reg_id = REG_NCFG;   map_ok = !wide; end
        10'h041: begin reg_id = REG_ECFG;   map_ok = !wide; end
        10'h002, 10'h003: begin reg_id = REG_NBYTES; map_ok = 1'b1; end
        10'h004, 10'h005: begin reg_id = REG_NDST;   map_ok = 1'b1; end
        10'h006, 10'h007: begin reg_id = REG_NSRC;   map_ok = 1'b1; end
        10'h042, 10'h043: begin reg_id = REG_EBYTES; map_ok = 1'b1; end
        10'h044, 10'h045: begin reg_id = REG_EDST;   map_ok = 1'b1; end
        10'h046, 10'h047: begin reg_id = REG_ESRC;   map_ok = 1'b1; end
        default: map_ok = 1'b0;
      endcase
      // upper half of a 64-bit register: 4-byte only
      if (offset[2] && (reg_id != REG_CTRL) && (reg_id != REG_NCFG) &&
          (reg_id != REG_ECFG)) begin
        if (wide) map_ok = 1'b0;
        part = PART_HI;
      end
    end
    hit = valid && chan_ok && map_ok;
    bad = valid && !(chan_ok && map_ok);
  end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter int MAX_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  reg_id_e     acc_reg,
  input  part_e       acc_part,
  input  logic [63:0] wdata,
  input  logic        eng_done,
  input  logic        eng_err,
  output logic [63:0] rd_data,
  output logic        start,
  output desc_t       exec_desc,
  output logic        irq_done,
  output logic        irq_err
);
  logic [31:0] ctrl_q, ctrl_d;
  logic [31:0] ncfg_q;
  logic [63:0] nbytes_q, ndst_q, nsrc_q;
  desc_t       exec_q;
  logic        active_q, active_d;
  logic        start_q;
  logic        launch, desc_ok;
  logic        ncfg_en, nbytes_en, ndst_en, nsrc_en;

  dmareg_desc_chk #(.MAX_LOG2(MAX_LOG2)) u_desc_chk (
    .cfg   (ncfg_q),
    .bytes (nbytes_q),
    .ok    (desc_ok)
  );

  // next-state: control and busy tracking
  always_comb begin
    ctrl_d   = ctrl_q;
    active_d = active_q;
    launch   = 1'b0;
    if (active_q && (eng_done || eng_err)) begin
      active_d         = 1'b0;
      ctrl_d[CTRL_RUN] = 1'b0;
      if (eng_done) ctrl_d[CTRL_DONE] = 1'b1;
      if (eng_err)  ctrl_d[CTRL_ERR]  = 1'b1;
    end
    if (wr_en && (acc_reg == REG_CTRL)) begin
      if (active_q) begin
        ctrl_d[CTRL_DIE] = wdata[CTRL_DIE];
        ctrl_d[CTRL_EIE] = wdata[CTRL_EIE];
      end else begin
        ctrl_d = wdata[31:0] & CTRL_MASK;
        if (wdata[CTRL_RUN]) begin
          if (desc_ok) begin
            launch            = 1'b1;
            active_d          = 1'b1;
            ctrl_d[CTRL_DONE] = 1'b0;
            ctrl_d[CTRL_ERR]  = 1'b0;
          end else begin
            ctrl_d[CTRL_ERR]  = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    ncfg_en   = wr_en && (acc_reg == REG_NCFG);
    nbytes_en = wr_en && (acc_reg == REG_NBYTES);
    ndst_en   = wr_en && (acc_reg == REG_NDST);
    nsrc_en   = wr_en && (acc_reg == REG_NSRC);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      active_q <= 1'b0;
      start_q  <= 1'b0;
      ncfg_q   <= '0;
      nbytes_q <= '0;
      ndst_q   <= '0;
      nsrc_q   <= '0;
      exec_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      active_q <= active_d;
      start_q  <= launch;
      if (ncfg_en)   ncfg_q   <= wdata[31:0];
      if (nbytes_en) nbytes_q <= merge_part(nbytes_q, acc_part, wdata);
      if (ndst_en)   ndst_q   <= merge_part(ndst_q, acc_part, wdata);
      if (nsrc_en)   nsrc_q   <= merge_part(nsrc_q, acc_part, wdata);
      if (launch)    exec_q   <= '{cfg: ncfg_q, bytes: nbytes_q,
                                   dst: ndst_q, src: nsrc_q};
    end
  end

  // read mux
  always_comb begin
    case (acc_reg)
      REG_CTRL:   rd_data = {32'h0, ctrl_q};
      REG_NCFG:   rd_data = {32'h0, ncfg_q};
      REG_NBYTES: rd_data = pick_part(nbytes_q, acc_part);
      REG_NDST:   rd_data = pick_part(ndst_q, acc_part);
      REG_NSRC:   rd_data = pick_part(nsrc_q, acc_part);
      REG_ECFG:   rd_data = {32'h0, exec_q.cfg};
      REG_EBYTES: rd_data = pick_part(exec_q.bytes, acc_part);
      REG_EDST:   rd_data = pick_part(exec_q.dst, acc_part);
      REG_ESRC:   rd_data = pick_part(exec_q.src, acc_part);
      default:    rd_data = 64'h0;
    endcase
  end

  assign start     = start_q;
  assign exec_desc = exec_q;
  assign irq_done  = ctrl_q[CTRL_DONE] && ctrl_q[CTRL_DIE];
  assign irq_err   = ctrl_q[CTRL_ERR] && ctrl_q[CTRL_EIE];
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 16,
  parameter int MAX_LOG2 = 6,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic                bus_wide,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [63:0]         bus_wdata,
  output logic                bus_rvalid,
  output logic [63:0]         bus_rdata,
  output logic                bad_access,
  input  logic [NUM_CH-1:0]   eng_done,
  input  logic [NUM_CH-1:0]   eng_err,
  output logic                start_valid,
  output logic [CH_W-1:0]     start_chan,
  output logic [31:0]         start_cfg,
  output logic [63:0]         start_bytes,
  output logic [63:0]         start_dst,
  output logic [63:0]         start_src,
  output logic [2*NUM_CH-1:0] irq
);
  logic            dec_hit, dec_bad;
  logic [CH_W-1:0] dec_chan;
  reg_id_e         dec_reg;
  part_e           dec_part;

  logic [63:0]       rd_vec   [NUM_CH];
  desc_t             exec_vec [NUM_CH];
  logic [NUM_CH-1:0] start_vec;

  logic        rvalid_q, rvalid_d;
  logic [63:0] rdata_q, rdata_d;
  logic        bad_q, bad_d;
  desc_t       st_desc;
  logic [CH_W-1:0] st_chan;

  dmareg_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_decode (
    .valid  (bus_valid),
    .wide   (bus_wide),
    .addr   (bus_addr),
    .hit    (dec_hit),
    .bad    (dec_bad),
    .chan   (dec_chan),
    .reg_id (dec_reg),
    .part   (dec_part)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic wr_sel;
    assign wr_sel = dec_hit && bus_write && (dec_chan == CH_W'(g));
    dmareg_chan #(.MAX_LOG2(MAX_LOG2)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_sel),
      .acc_reg   (dec_reg),
      .acc_part  (dec_part),
      .wdata     (bus_wdata),
      .eng_done  (eng_done[g]),
      .eng_err   (eng_err[g]),
      .rd_data   (rd_vec[g]),
      .start     (start_vec[g]),
      .exec_desc (exec_vec[g]),
      .irq_done  (irq[2*g]),
      .irq_err   (irq[2*g+1])
    );
  end

  // read path and bad-access flag next state
  always_comb begin
    rvalid_d = bus_valid && !bus_write;
    bad_d    = dec_bad;
    rdata_d  = 64'h0;
    if (dec_hit && !bus_write) rdata_d = rd_vec[dec_chan];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      bad_q    <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      bad_q    <= bad_d;
      if (rvalid_d) rdata_q <= rdata_d;
    end
  end

  // one launch at most per cycle: select the strobing channel
  always_comb begin
    st_desc = '0;
    st_chan = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (start_vec[i]) begin
        st_desc = exec_vec[i];
        st_chan = CH_W'(i);
      end
    end
  end

  assign bus_rvalid  = rvalid_q;
  assign bus_rdata   = rdata_q;
  assign bad_access  = bad_q;
  assign start_valid = |start_vec;
  assign start_chan  = st_chan;
  assign start_cfg   = st_desc.cfg;
  assign start_bytes = st_desc.bytes;
  assign start_dst   = st_desc.dst;
  assign start_src   = st_desc.src;
endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_valid,
  input logic                bus_write,
  input logic                bus_rvalid,
  input logic                bad_access,
  input logic [NUM_CH-1:0]   eng_done,
  input logic [NUM_CH-1:0]   eng_err,
  input logic                start_valid,
  input logic [63:0]         start_bytes,
  input logic [2*NUM_CH-1:0] irq
);
  // R3: a launch strobe follows a bus write by one cycle
  p_start_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> $past(bus_valid && bus_write));

  // R4: a launched descriptor never carries a zero byte count
  p_start_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> (start_bytes != 64'd0));

  // R6: interrupt lines move only after a write or an engine report
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != $past(irq)) |->
      $past((bus_valid && bus_write) || (|eng_done) || (|eng_err)));

  // R10: the bad-access flag follows an access
  p_bad_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(bus_valid));

  // R12: read data one cycle after a read request, and only then
  p_rvalid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  p_rvalid_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind dmareg_top dmareg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dmareg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_rvalid  (bus_rvalid),
  .bad_access  (bad_access),
  .eng_done    (eng_done),
  .eng_err     (eng_err),
  .start_valid (start_valid),
  .start_bytes (start_bytes),
  .irq         (irq)
);

// File: tb/dmareg_top_tb_top.sv
module dmareg_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int ADDR_W     = 16;
  localparam int CH_W       = 2;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                bus_valid, bus_write, bus_wide;
  logic [ADDR_W-1:0]   bus_addr;
  logic [63:0]         bus_wdata;
  logic                bus_rvalid;
  logic [63:0]         bus_rdata;
  logic                bad_access;
  logic [NUM_CH-1:0]   eng_done, eng_err;
  logic                start_valid;
  logic [CH_W-1:0]     start_chan;
  logic [31:0]         start_cfg;
  logic [63:0]         start_bytes, start_dst, start_src;
  logic [2*NUM_CH-1:0] irq;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [63:0] rd_val;
  logic        rd_ok, bad_seen, st_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmareg_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bad_access(bad_access),
    .eng_done(eng_done), .eng_err(eng_err), .start_valid(start_valid),
    .start_chan(start_chan), .start_cfg(start_cfg), .start_bytes(start_bytes),
    .start_dst(start_dst), .start_src(start_src), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] ad(input int ch, input int off);
    return ADDR_W'((ch << 12) | off);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input bit wide, input logic [63:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_wide = wide;
    bus_addr = ad(ch, off); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    bad_seen = bad_access; st_seen = start_valid;
  endtask

  task automatic rd(input int ch, input int off, input bit wide);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_wide = wide; bus_addr = ad(ch, off);
    @(negedge clk);
    bus_valid = 1'b0;
    rd_val = bus_rdata; rd_ok = bus_rvalid; bad_seen = bad_access;
  endtask

  task automatic eng(input int ch, input bit is_err);
    @(negedge clk);
    if (is_err) eng_err[ch] = 1'b1; else eng_done[ch] = 1'b1;
    @(negedge clk);
    eng_err = '0; eng_done = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 start", 64'(start_valid), 64'h0);
    rd(2, 12'h018, 1'b1); chk("R1 nsrc", rd_val, 64'h0);
    rd(0, 12'h000, 1'b0); chk("R1 ctrl", rd_val, 64'h0);
    chk("R12 rvalid", 64'(rd_ok), 64'h1);
  endtask

  task automatic t_next_regs;
    wr(1, 12'h008, 1'b1, 64'h1111_2222_3333_4444);
    rd(1, 12'h008, 1'b1); chk("R2 wide", rd_val, 64'h1111_2222_3333_4444);
    wr(1, 12'h00C, 1'b0, 64'hFFFF_FFFF_ABCD_0001);
    rd(1, 12'h008, 1'b1); chk("R2 hi write", rd_val, 64'hABCD_0001_3333_4444);
    rd(1, 12'h00C, 1'b0); chk("R12 hi read", rd_val, 64'h0000_0000_ABCD_0001);
    wr(1, 12'h004, 1'b0, 64'hFFFF_FFFF_0000_0004);
    rd(1, 12'h004, 1'b0); chk("R2 cfg", rd_val, 64'h4);
  endtask

  task automatic t_launch;
    wr(1, 12'h004, 1'b0, 64'h3300_0004);
    wr(1, 12'h008, 1'b1, 64'h40);
    wr(1, 12'h010, 1'b1, 64'hD000_0000_0000_1000);
    wr(1, 12'h018, 1'b1, 64'h5000_0000_0000_2000);
    wr(1, 12'h000, 1'b0, 64'hC002);
    chk("R3 start", 64'(st_seen), 64'h1);
    chk("R3 chan", 64'(start_chan), 64'h1);
    chk("R3 bytes", start_bytes, 64'h40);
    chk("R3 dst", start_dst, 64'hD000_0000_0000_1000);
    chk("R3 src", start_src, 64'h5000_0000_0000_2000);
    chk("R3 cfg", 64'(start_cfg), 64'h3300_0004);
    rd(1, 12'h104, 1'b0); chk("R3 exec cfg", rd_val, 64'h3300_0004);
    rd(1, 12'h108, 1'b1); chk("R3 exec bytes", rd_val, 64'h40);
    rd(1, 12'h11C, 1'b0); chk("R3 exec src hi", rd_val, 64'h5000_0000);
    rd(1, 12'h000, 1'b0); chk("R3 ctrl", rd_val, 64'hC002);
  endtask

  task automatic t_busy;
    wr(1, 12'h000, 1'b0, 64'h0002);
    chk("R7 no restart", 64'(st_seen), 64'h0);
    rd(1, 12'h000, 1'b0); chk("R7 ie only", rd_val, 64'h0002);
    wr(1, 12'h000, 1'b0, 64'h0000_C000);
    rd(1, 12'h000, 1'b0); chk("R7 run kept", rd_val, 64'hC002);
  endtask

  task automatic t_done;
    eng(1, 1'b0);
    chk("R6 done irq", 64'(irq[3:2]), 64'h1);
    rd(1, 12'h000, 1'b0); chk("R5 done status", rd_val, 64'h4000_C000);
    wr(1, 12'h000, 1'b0, 64'h4000_0000);
    chk("R6 done masked", 64'(irq[2]), 64'h0);
  endtask

  task automatic t_invalid;
    wr(2, 12'h000, 1'b0, 64'h8002);
    chk("R4 zero bytes start", 64'(st_seen), 64'h0);
    chk("R6 err irq", 64'(irq[5:4]), 64'h2);
    rd(2, 12'h000, 1'b0); chk("R4 zero bytes err", rd_val, 64'h8000_8002);
    wr(3, 12'h004, 1'b0, 64'h2300_0000);
    wr(3, 12'h008, 1'b1, 64'h10);
    wr(3, 12'h000, 1'b0, 64'h2);
    chk("R4 size mismatch", 64'(st_seen), 64'h0);
    rd(3, 12'h000, 1'b0); chk("R4 mismatch err", rd_val, 64'h8000_0002);
    wr(3, 12'h004, 1'b0, 64'h3300_0000);
    wr(3, 12'h008, 1'b1, 64'hC);
    wr(3, 12'h000, 1'b0, 64'h2);
    rd(3, 12'h000, 1'b0); chk("R4 not multiple", rd_val, 64'h8000_0002);
    wr(3, 12'h004, 1'b0, 64'h9900_0000);
    wr(3, 12'h008, 1'b1, 64'h60);
    wr(3, 12'h000, 1'b0, 64'h2);
    chk("R4 clamp 96 rejected", 64'(st_seen), 64'h0);
    wr(3, 12'h008, 1'b1, 64'h80);
    wr(3, 12'h000, 1'b0, 64'h2);
    chk("R4 clamp 128 accepted", 64'(st_seen), 64'h1);
    chk("R3 chan 3", 64'(start_chan), 64'h3);
    eng(3, 1'b0);
  endtask

  task automatic t_err;
    wr(0, 12'h004, 1'b0, 64'h0);
    wr(0, 12'h008, 1'b1, 64'h5);
    wr(0, 12'h000, 1'b0, 64'h8002);
    chk("R3 ch0 start", 64'(st_seen), 64'h1);
    eng(0, 1'b1);
    chk("R6 err line", 64'(irq[1:0]), 64'h2);
    rd(0, 12'h000, 1'b0); chk("R5 err status", rd_val, 64'h8000_8000);
  endtask

  task automatic t_exec_ro;
    wr(1, 12'h108, 1'b1, 64'hDEAD);
    rd(1, 12'h108, 1'b1); chk("R8 exec dropped", rd_val, 64'h40);
  endtask

  task automatic t_bad_chan;
    wr(5, 12'h008, 1'b1, 64'h77);
    chk("R9 write flag", 64'(bad_seen), 64'h1);
    rd(5, 12'h008, 1'b1);
    chk("R9 read zero", rd_val, 64'h0);
    chk("R9 read flag", 64'(bad_seen), 64'h1);
    rd(1, 12'h008, 1'b1); chk("R9 no alias", rd_val, 64'h40);
    chk("R10 good no flag", 64'(bad_seen), 64'h0);
  endtask

  task automatic t_bad_off;
    rd(0, 12'h020, 1'b0);
    chk("R10 unmapped flag", 64'(bad_seen), 64'h1);
    chk("R10 unmapped zero", rd_val, 64'h0);
    wr(0, 12'h00A, 1'b0, 64'h1);
    chk("R10 misaligned", 64'(bad_seen), 64'h1);
    wr(0, 12'h000, 1'b1, 64'h4000);
    chk("R10 wide ctrl", 64'(bad_seen), 64'h1);
    rd(0, 12'h000, 1'b0); chk("R10 ctrl untouched", rd_val, 64'h8000_8000);
    wr(0, 12'h00C, 1'b1, 64'h9);
    rd(0, 12'h008, 1'b1); chk("R10 wide hi dropped", rd_val, 64'h5);
  endtask

  task automatic t_isolation;
    wr(0, 12'h010, 1'b1, 64'hA0A0);
    wr(3, 12'h010, 1'b1, 64'hB3B3);
    rd(0, 12'h010, 1'b1); chk("R11 ch0", rd_val, 64'hA0A0);
    rd(3, 12'h010, 1'b1); chk("R11 ch3", rd_val, 64'hB3B3);
    rd(2, 12'h010, 1'b1); chk("R11 ch2", rd_val, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_wide = 1'b0;
    bus_addr = '0; bus_wdata = '0; eng_done = '0; eng_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_next_regs();
    t_launch();
    t_busy();
    t_done();
    t_invalid();
    t_err();
    t_exec_ro();
    t_bad_chan();
    t_bad_off();
    t_isolation();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule